// File: doc/BRIEF.md
# Per-Load Stride Prefetch Predictor

This block watches the stream of executed loads. Each load gives its program counter and its effective address. A small direct-mapped table, indexed by the low bits of the program counter, keeps a record for each load. The record holds the upper PC bits as a tag, the address seen last time, a learned stride and a two-bit confidence state. Every load either refreshes its own record or, on a tag mismatch or an empty slot, takes the slot over.

A four-state confidence machine decides whether a mismatch replaces the learned stride and when the record is trusted. The states are initial, transient, steady and no-prediction. When a load leaves its record steady with a non-zero stride, the block puts out a one-cycle prefetch strobe on the next clock. The strobe carries the address one stride ahead of the current load. The consumer of that strobe sits outside this block.

Top module: `stride_pf_table`

## Requirements
- R1: After a synchronous active-low reset, `pf_valid` is 0 and every table slot is empty, so the first load of any PC allocates and does not prefetch.
- R2: A load whose slot is empty or holds another tag allocates the slot with its tag, prev = its address, stride = 0, state initial, and issues no prefetch.
- R3: A load that hits its slot is "correct" when its address equals prev + stride modulo 2^ADDR_W. Otherwise it is incorrect, and the observed delta is address − prev.
- R4: From initial, a correct load moves to steady. An incorrect load moves to transient and stores the delta as the stride.
- R5: From transient, a correct load moves to steady. An incorrect load moves to no-prediction and stores the delta.
- R6: From steady, a correct load stays steady. An incorrect load moves to initial and keeps the old stride.
- R7: From no-prediction, a correct load moves to transient. An incorrect load stays in no-prediction and stores the delta.
- R8: When a hitting load leaves its slot steady with a non-zero stride, `pf_valid` is 1 for exactly the cycle after that load's clock edge, with `pf_addr` = address + stride modulo 2^ADDR_W. Otherwise `pf_valid` is 0 in that cycle.
- R9: A stride of zero never produces a prefetch, even in the steady state.
- R10: Every load, hit or allocate, writes its address into its slot's prev field.
- R11: The slot index is `ld_pc[IDX_W-1:0]`, where IDX_W = log2(ENTRIES) and ENTRIES defaults to 16. The tag is the remaining upper PC bits. PCs that differ only in their tag evict each other.
- R12: Negative strides, held in two's complement as address differences, are learned and predicted the same way as positive ones.
- R13: A cycle without `ld_valid` changes no slot and gives `pf_valid` = 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_pc | input | PC_W | Program counter of the load |
| ld_addr | input | ADDR_W | Effective address of the load |
| pf_valid | output | 1 | Prefetch request strobe, one cycle |
| pf_addr | output | ADDR_W | Address to prefetch |

## Verification
Two functions can coincide in one cycle: evicting a record through a tag conflict, and deciding a prefetch for the same slot. The bench trains a PC to steady, then sends a load from a PC that shares its index but not its tag, continuing the same arithmetic progression. The bench expects no strobe for that load, and it expects the original PC to start over from initial when it returns. The other coincidence is a table write followed at once by a read of the same slot. Back-to-back loads of one PC in consecutive cycles provoke it, and each one is judged against a model kept in the bench.

// File: rtl/spt_pkg.sv
// Package: shared confidence-state encoding and transition rules for the
// stride prediction table. Assumes a two-bit state per table slot.
package spt_pkg;

    typedef enum logic [1:0] {
        CF_INIT   = 2'd0,
        CF_TRANS  = 2'd1,
        CF_STEADY = 2'd2,
        CF_NOPRED = 2'd3
    } conf_t;

    // Next confidence state given the current state and prediction outcome.
    function automatic conf_t conf_next(input conf_t cur, input logic ok);
        conf_t nxt;
        case (cur)
            CF_INIT:   nxt = ok ? CF_STEADY : CF_TRANS;
            CF_TRANS:  nxt = ok ? CF_STEADY : CF_NOPRED;
            CF_STEADY: nxt = ok ? CF_STEADY : CF_INIT;
            default:   nxt = ok ? CF_TRANS  : CF_NOPRED;
        endcase
        return nxt;
    endfunction

    // Whether a mispredicting load replaces the stored stride.
    function automatic logic conf_takes_delta(input conf_t cur, input logic ok);
        return !ok && (cur != CF_STEADY);
    endfunction

endpackage

// File: rtl/spt_store.sv
// Module: register storage for the direct-mapped prediction table.
// One combinational read port and one write port, both on the same index;
// a write lands at the clock edge, so the next cycle reads the new record.
// Assumes only the per-slot valid bits need reset.
module spt_store
    import spt_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 28,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [ADDR_W-1:0] rd_prev,
    output logic [ADDR_W-1:0] rd_stride,
    output conf_t             rd_state,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_prev,
    input  logic [ADDR_W-1:0] wr_stride,
    input  conf_t             wr_state
);

    logic              slot_v      [ENTRIES];
    logic [TAG_W-1:0]  slot_tag    [ENTRIES];
    logic [ADDR_W-1:0] slot_prev   [ENTRIES];
    logic [ADDR_W-1:0] slot_stride [ENTRIES];
    conf_t             slot_state  [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        logic hit_w;
        assign hit_w = wr_en && (idx == IDX_W'(e));

        // Valid bit: cleared by reset, set by the first write to the slot.
        always_ff @(posedge clk) begin
            if (!rst_n)     slot_v[e] <= 1'b0;
            else if (hit_w) slot_v[e] <= 1'b1;
        end

        // Record fields: overwritten on each write, guarded by the valid bit.
        always_ff @(posedge clk) begin
            if (hit_w) begin
                slot_tag[e]    <= wr_tag;
                slot_prev[e]   <= wr_prev;
                slot_stride[e] <= wr_stride;
                slot_state[e]  <= wr_state;
            end
        end
    end

    // Read port: select the addressed slot.
    always_comb begin
        rd_valid  = slot_v[idx];
        rd_tag    = slot_tag[idx];
        rd_prev   = slot_prev[idx];
        rd_stride = slot_stride[idx];
        rd_state  = slot_state[idx];
    end

endmodule

// File: rtl/spt_update.sv
// Module: combinational update for one load. Decides hit or allocate,
// checks the prediction, forms the record to write back and the prefetch
// decision. Assumes the read record belongs to the load's index.
module spt_update
    import spt_pkg::*;
#(
    parameter int TAG_W  = 28,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              rd_valid,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [ADDR_W-1:0] rd_prev,
    input  logic [ADDR_W-1:0] rd_stride,
    input  conf_t             rd_state,
    output logic              hit,
    output logic [ADDR_W-1:0] new_stride,
    output conf_t             new_state,
    output logic              fire,
    output logic [ADDR_W-1:0] fire_addr
);

    logic [ADDR_W-1:0] delta;
    logic              ok;

    // Hit detection and prediction outcome.
    always_comb begin
        hit   = rd_valid && (rd_tag == ld_tag);
        delta = ld_addr - rd_prev;
        ok    = (delta == rd_stride);
    end

    // Next record contents and prefetch decision.
    always_comb begin
        if (hit) begin
            new_state  = conf_next(rd_state, ok);
            new_stride = conf_takes_delta(rd_state, ok) ? delta : rd_stride;
        end else begin
            new_state  = CF_INIT;
            new_stride = '0;
        end
        fire      = ld_valid && hit && (new_state == CF_STEADY) && (new_stride != '0);
        fire_addr = ld_addr + new_stride;
    end

    // A steady record that mispredicts falls back without losing its stride.
    p_keep_stride_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && hit && rd_state == CF_STEADY && !ok) |->
            (new_stride == rd_stride && new_state == CF_INIT));

    // From initial or transient, a correct load always lands in steady.
    p_confirm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && hit && ok && (rd_state == CF_INIT || rd_state == CF_TRANS))
            |-> (new_state == CF_STEADY));

    // An allocating load never asks for a prefetch.
    p_alloc_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !hit) |-> !fire);

endmodule

// File: rtl/spt_pf_out.sv
// Module: registered prefetch output. Turns the per-load decision into a
// one-cycle strobe with its address. Assumes no back-pressure downstream.
module spt_pf_out #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [ADDR_W-1:0] fire_addr,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);

    // Output register: strobe and address captured at the load's edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else begin
            pf_valid <= fire;
            if (fire) pf_addr <= fire_addr;
        end
    end

endmodule

// File: rtl/stride_pf_table.sv
// Module: top of the stride prefetch predictor. Splits the PC into index
// and tag, reads the slot, updates it and registers the prefetch request.
// Assumes at most one load per cycle and ENTRIES a power of two.
module stride_pf_table
    import spt_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [PC_W-1:0]   ld_pc,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W;

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [ADDR_W-1:0] rd_prev;
    logic [ADDR_W-1:0] rd_stride;
    conf_t             rd_state;
    logic              hit;
    logic [ADDR_W-1:0] new_stride;
    conf_t             new_state;
    logic              fire;
    logic [ADDR_W-1:0] fire_addr;

    // PC split: low bits index the table, the rest form the tag.
    always_comb begin
        idx = ld_pc[IDX_W-1:0];
        tag = ld_pc[PC_W-1:IDX_W];
    end

    spt_store #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .ADDR_W  (ADDR_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_prev   (rd_prev),
        .rd_stride (rd_stride),
        .rd_state  (rd_state),
        .wr_en     (ld_valid),
        .wr_tag    (tag),
        .wr_prev   (ld_addr),
        .wr_stride (new_stride),
        .wr_state  (new_state)
    );

    spt_update #(
        .TAG_W  (TAG_W),
        .ADDR_W (ADDR_W)
    ) u_update (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_valid   (ld_valid),
        .ld_tag     (tag),
        .ld_addr    (ld_addr),
        .rd_valid   (rd_valid),
        .rd_tag     (rd_tag),
        .rd_prev    (rd_prev),
        .rd_stride  (rd_stride),
        .rd_state   (rd_state),
        .hit        (hit),
        .new_stride (new_stride),
        .new_state  (new_state),
        .fire       (fire),
        .fire_addr  (fire_addr)
    );

    spt_pf_out #(
        .ADDR_W (ADDR_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .fire_addr (fire_addr),
        .pf_valid  (pf_valid),
        .pf_addr   (pf_addr)
    );

    // A strobe only follows a cycle that carried a hitting load.
    p_strobe_source_r13: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> $past(ld_valid && hit));

    // A strobe never points at the load's own address (stride is non-zero).
    p_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_addr != $past(ld_addr)));

    // The strobe lasts one cycle unless another load fired it again.
    p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !ld_valid) |=> !pf_valid);

endmodule

// File: tb/stride_pf_table_tb.sv
module stride_pf_table_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W = 32;
    localparam int AW   = 32;
    localparam int NE   = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_valid = 1'b0;
    logic [PC_W-1:0] ld_pc = '0;
    logic [AW-1:0] ld_addr = '0;
    logic          pf_valid;
    logic [AW-1:0] pf_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model of the table (0 init, 1 transient, 2 steady, 3 no-prediction).
    bit          m_v   [NE];
    logic [27:0] m_tag [NE];
    logic [AW-1:0] m_prev [NE];
    logic [AW-1:0] m_str  [NE];
    int          m_st  [NE];
    int          cnt   [NE];

    always #(CLK_PERIOD/2) clk = ~clk;

    stride_pf_table #(.PC_W(PC_W), .ADDR_W(AW), .ENTRIES(NE)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_pc(ld_pc),
        .ld_addr(ld_addr), .pf_valid(pf_valid), .pf_addr(pf_addr)
    );

    task automatic check_pf(input bit ev, input logic [AW-1:0] ea, input string tag);
        checks++;
        if (pf_valid !== ev || (ev && pf_addr !== ea)) begin
            errors++;
            $display("FAIL %s: pf_valid=%0b pf_addr=%h expected valid=%0b addr=%h",
                     tag, pf_valid, pf_addr, ev, ea);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NE; i++) m_v[i] = 0;
    endtask

    // Model one load; returns expected strobe and address.
    task automatic model_load(input logic [PC_W-1:0] pc, input logic [AW-1:0] a,
                              output bit ev, output logic [AW-1:0] ea);
        int k;
        logic [AW-1:0] d;
        bit ok;
        k = int'(pc[3:0]);
        ev = 0; ea = '0;
        if (!m_v[k] || m_tag[k] != pc[31:4]) begin
            m_v[k] = 1; m_tag[k] = pc[31:4]; m_str[k] = '0; m_st[k] = 0;
        end else begin
            d = a - m_prev[k];
            ok = (d == m_str[k]);
            case (m_st[k])
                0: begin if (ok) m_st[k] = 2; else begin m_st[k] = 1; m_str[k] = d; end end
                1: begin if (ok) m_st[k] = 2; else begin m_st[k] = 3; m_str[k] = d; end end
                2: begin if (!ok) m_st[k] = 0; end
                default: begin if (ok) m_st[k] = 1; else m_str[k] = d; end
            endcase
            if (m_st[k] == 2 && m_str[k] != '0) begin ev = 1; ea = a + m_str[k]; end
        end
        m_prev[k] = a;
    endtask

    // Drive one load, then check the registered result after the edge.
    task automatic do_load(input logic [PC_W-1:0] pc, input logic [AW-1:0] a, input string tag);
        bit ev;
        logic [AW-1:0] ea;
        model_load(pc, a, ev, ea);
        @(negedge clk);
        ld_valid = 1'b1; ld_pc = pc; ld_addr = a;
        @(posedge clk); #1;
        check_pf(ev, ea, tag);
    endtask

    task automatic do_idle(input string tag);
        @(negedge clk);
        ld_valid = 1'b0; ld_pc = $urandom; ld_addr = $urandom;
        @(posedge clk); #1;
        check_pf(1'b0, '0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ld_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();
        #1 check_pf(1'b0, '0, "R1 reset strobe low");

        // R2/R4: allocate, mispredict to transient, confirm to steady.
        do_load(32'h0000_1003, 32'h2000, "R2 allocate no prefetch");
        do_load(32'h0000_1003, 32'h2008, "R4 init incorrect to transient");
        do_load(32'h0000_1003, 32'h2010, "R8 steady prefetch");
        // R6: steady mispredict keeps stride, back to initial.
        do_load(32'h0000_1003, 32'h2100, "R6 steady incorrect no prefetch");
        do_load(32'h0000_1003, 32'h2108, "R6 old stride kept, init correct to steady");
        // R4: initial incorrect stores the new delta.
        do_load(32'h0000_1003, 32'h2110, "R8 steady again");
        do_load(32'h0000_1003, 32'h3000, "R6 fall to initial");
        do_load(32'h0000_1003, 32'h3030, "R4 initial incorrect takes delta");
        do_load(32'h0000_1003, 32'h3060, "R4 transient correct to steady");

        // R5: transient incorrect -> no-prediction; then R7 climb back.
        do_load(32'h0000_2005, 32'h8000, "R2 allocate");
        do_load(32'h0000_2005, 32'h8004, "R5 to transient");
        do_load(32'h0000_2005, 32'h800A, "R5 transient incorrect to noPred");
        do_load(32'h0000_2005, 32'h8010, "R7 noPred correct to transient");
        do_load(32'h0000_2005, 32'h8016, "R5 transient correct to steady");

        // R7: no-prediction incorrect stays and learns the new delta.
        do_load(32'h0000_3006, 32'h9000, "R2 allocate");
        do_load(32'h0000_3006, 32'h9004, "R7 setup");
        do_load(32'h0000_3006, 32'h900A, "R7 enter noPred");
        do_load(32'h0000_3006, 32'h900D, "R7 noPred incorrect stays");
        do_load(32'h0000_3006, 32'h9010, "R7 correct to transient");
        do_load(32'h0000_3006, 32'h9013, "R7 then steady");

        // R9: repeated same address reaches steady with zero stride.
        do_load(32'h0000_4007, 32'h5000, "R9 allocate");
        do_load(32'h0000_4007, 32'h5000, "R9 zero stride steady no prefetch");
        do_load(32'h0000_4007, 32'h5000, "R9 still none");

        // R12: negative stride.
        do_load(32'h0000_5008, 32'h7000, "R12 allocate");
        do_load(32'h0000_5008, 32'h6FF0, "R12 learn -16");
        do_load(32'h0000_5008, 32'h6FE0, "R12 negative prefetch");

        // R11: conflicting tag on same index evicts the steady record.
        do_load(32'h0000_6008, 32'h6FD0, "R11 conflict allocates, no prefetch");
        do_load(32'h0000_5008, 32'h6FC0, "R11 original PC reallocates");
        do_load(32'h0000_5008, 32'h6FB0, "R10 prev tracked, to transient");

        // R13: idle cycles change nothing.
        do_idle("R13 idle no strobe");
        do_idle("R13 idle no strobe");
        do_load(32'h0000_5008, 32'h6FA0, "R13 record intact after idle");

        // R1: reset empties a steady record.
        do_reset();
        do_load(32'h0000_5008, 32'h6F90, "R1 reset cleared table");

        // R3/R8/R10/R11/R12 sweep: all indices, three tags, mixed strides.
        for (int i = 0; i < NE; i++) cnt[i] = 0;
        for (int i = 0; i < 960; i++) begin
            int ix;
            int tg;
            logic [AW-1:0] st;
            logic [AW-1:0] a;
            ix = (i * 7) % NE;
            tg = (i / 160) % 3;
            st = AW'((ix - 7) * 4 + tg);
            a  = 32'h1000_0000 + AW'(ix) * 32'h1_0000 + AW'(cnt[ix]) * st;
            if (i % 13 == 5) a = a + 32'd12;
            cnt[ix]++;
            do_load({24'h0, 4'(tg), ix[3:0]}, a, "R3 R8 sweep");
            if (i % 17 == 0) do_idle("R13 sweep idle");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule